// File: doc/BRIEF.md
# Processor Status Word Condition Flag Unit

This block keeps a 16-bit processor status word and refreshes its condition-status field from the outcome of each arithmetic or logical operation. The datapath presents a result of either 16 or 32 bits, a width select, the adder's carry or borrow indication, and the kind of operation. On an update strobe the block derives carry, positive, zero and negative flags and stores them. The other three fields are left untouched by the update. These fields are a page-bank select, a processor-state nibble and an address-state nibble.

Software may load the whole word in one cycle, and the word is always visible on a read-back port. A mode input selects one of two architecture variants. In the reduced variant the page-bank nibble is held at zero and reads as zero. In the extended variant it stores the value software writes. The numbering convention puts architectural bit 0 at the most significant position, so architectural bit k appears on `sw_o[15-k]`.

The block has no state machine. Every decision is a one-cycle register load chosen by priority: reset, then write, then flag update, then hold.

Top module: `swf_unit`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `sw_o` is 16'h0000.
- R2: The field layout is `sw_o[15]` carry, `sw_o[14]` positive, `sw_o[13]` zero, `sw_o[12]` negative, `sw_o[11:8]` page-bank select, `sw_o[7:4]` processor state and `sw_o[3:0]` address state. Architectural bit 0 is `sw_o[15]`.
- R3: On a flag update the carry bit is set as follows. For add (`op_i`=2'b00) it takes `cb_i`, the carry out. For subtract (`op_i`=2'b01) it takes the inverse of `cb_i`, the borrow, so that carry means "no borrow". For logical operations (`op_i`=2'b10 or 2'b11) it is 0.
- R4: On a flag update the positive, zero and negative bits show whether the result, read as two's complement, is greater than, equal to or less than zero. Exactly one of the three is 1 afterwards.
- R5: With `wide_i`=1 the sign and zero tests use all 32 bits of `res_i`. With `wide_i`=0 they use `res_i[15:0]` only, and `res_i[31:16]` has no effect.
- R6: While `ext_mode_i`=0, `sw_o[11:8]` reads 0. Writes to that nibble are discarded, and the stored nibble is cleared, so it is still 0 after a switch to `ext_mode_i`=1.
- R7: While `ext_mode_i`=1, a write loads `wr_data_i[11:8]` into the page-bank nibble. The nibble then holds its value through flag updates and idle cycles.
- R8: A flag update (`upd_i`=1, `wr_i`=0) changes only `sw_o[15:12]`. With neither `upd_i` nor `wr_i` asserted, the word holds.
- R9: A write (`wr_i`=1) loads `wr_data_i` into the whole word, subject to R6, on the next clock edge. It takes priority over a flag update in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| res_i | input | 32 | Operation result; low 16 bits used for narrow results |
| wide_i | input | 1 | 1 = 32-bit result, 0 = 16-bit result |
| cb_i | input | 1 | Adder carry out on add, borrow on subtract |
| op_i | input | 2 | Operation kind: 00 add, 01 subtract, 10/11 logical |
| upd_i | input | 1 | Load condition flags from this cycle's result |
| ext_mode_i | input | 1 | 0 = reduced variant, 1 = extended variant with page-bank field |
| wr_i | input | 1 | Software write of the whole status word |
| wr_data_i | input | 16 | Word to write |
| sw_o | output | 16 | Current status word |

## Verification
Each register loads directly onto the read-back port, so a wrong internal value appears at `sw_o` on the first falling edge after the clock that loaded it. The bench compares the whole word in every cycle, and a fault is reported within one cycle of its cause. A wrongly held page-bank nibble is different: it stays hidden while the reduced mode masks it. It shows up only in the first cycle after the mode switches to the extended variant, which is why the bench runs that switch deliberately. Narrow and wide results that differ only in the upper half are applied so that a wrong choice of width moves a flag at once.

// File: rtl/swf_pkg.sv
package swf_pkg;
    typedef enum logic [1:0] {
        OPK_ADD   = 2'b00,
        OPK_SUB   = 2'b01,
        OPK_LOGIC = 2'b10,
        OPK_LALT  = 2'b11
    } opk_e;

    localparam int FLD_W  = 4;
    localparam int WORD_W = 4 * FLD_W;
endpackage

// File: rtl/swf_cond.sv
module swf_cond
    import swf_pkg::*;
#(
    parameter int DW = 32,
    parameter int NW = 16
) (
    input  logic [DW-1:0] res_i,
    input  logic          wide_i,
    input  logic          cb_i,
    input  opk_e          op_i,
    output logic [3:0]    cc_o     // {C, P, Z, N}
);
    logic is_zero;
    logic is_neg;
    logic carry;

    generate
        if (NW < DW) begin : g_split
            always_comb begin
                if (wide_i) begin
                    is_zero = (res_i == '0);
                    is_neg  = res_i[DW-1];
                end else begin
                    is_zero = (res_i[NW-1:0] == '0);
                    is_neg  = res_i[NW-1];
                end
            end
        end else begin : g_single
            always_comb begin
                is_zero = (res_i == '0);
                is_neg  = res_i[DW-1];
            end
        end
    endgenerate

    always_comb begin
        unique case (op_i)
            OPK_ADD:   carry = cb_i;
            OPK_SUB:   carry = ~cb_i;
            OPK_LOGIC,
            OPK_LALT:  carry = 1'b0;
            default:   carry = 1'b0;
        endcase
    end

    assign cc_o = {carry, ~is_zero & ~is_neg, is_zero, is_neg};
endmodule

// File: rtl/swf_bank.sv
module swf_bank #(
    parameter int FW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_i,
    input  logic          wr_i,
    input  logic [FW-1:0] wd_i,
    output logic [FW-1:0] bank_o
);
    logic [FW-1:0] bank_q;

    always_ff @(posedge clk) begin
        if (!rst_n)       bank_q <= '0;
        else if (!mode_i) bank_q <= '0;
        else if (wr_i)    bank_q <= wd_i;
    end

    assign bank_o = mode_i ? bank_q : '0;

    AST_BANK_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_i |=> (bank_q == '0)); // R6

    AST_BANK_RETAINED: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i && !wr_i) |=> $stable(bank_q)); // R7
endmodule

// File: rtl/swf_unit.sv
module swf_unit
    import swf_pkg::*;
#(
    parameter int DW = 32,
    parameter int NW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] res_i,
    input  logic          wide_i,
    input  logic          cb_i,
    input  logic [1:0]    op_i,
    input  logic          upd_i,
    input  logic          ext_mode_i,
    input  logic          wr_i,
    input  logic [15:0]   wr_data_i,
    output logic [15:0]   sw_o
);
    localparam int LOW_W = 2 * FLD_W;
    localparam int CC_LO = WORD_W - FLD_W;
    localparam int BK_LO = WORD_W - 2 * FLD_W;

    logic [FLD_W-1:0] cc_next;
    logic [FLD_W-1:0] cc_q;
    logic [LOW_W-1:0] low_q;
    logic [FLD_W-1:0] bank_w;

    swf_cond #(.DW(DW), .NW(NW)) u_cond (
        .res_i  (res_i),
        .wide_i (wide_i),
        .cb_i   (cb_i),
        .op_i   (opk_e'(op_i)),
        .cc_o   (cc_next)
    );

    swf_bank #(.FW(FLD_W)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode_i (ext_mode_i),
        .wr_i   (wr_i),
        .wd_i   (wr_data_i[BK_LO +: FLD_W]),
        .bank_o (bank_w)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cc_q  <= '0;
            low_q <= '0;
        end else if (wr_i) begin
            cc_q  <= wr_data_i[CC_LO +: FLD_W];
            low_q <= wr_data_i[LOW_W-1:0];
        end else if (upd_i) begin
            cc_q  <= cc_next;
        end
    end

    assign sw_o = {cc_q, bank_w, low_q};

    AST_ONE_SIGN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && !wr_i) |=> ($countones(sw_o[14:12]) == 1)); // R4

    AST_LOGIC_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && !wr_i && op_i[1]) |=> !sw_o[15]); // R3

    AST_UPDATE_KEEPS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && !wr_i) |=> $stable(sw_o[7:0])); // R8

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (sw_o[15:12] == $past(wr_data_i[15:12]) &&
                  sw_o[7:0]   == $past(wr_data_i[7:0]))); // R9

    AST_BANK_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_mode_i |-> (sw_o[11:8] == 4'h0)); // R6
endmodule

// File: tb/test_swf_unit.sv
module test_swf_unit;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] res_i;
    logic        wide_i, cb_i, upd_i, ext_mode_i, wr_i;
    logic [1:0]  op_i;
    logic [15:0] wr_data_i;
    logic [15:0] sw_o;

    int n_vec = 0;
    int n_bad = 0;
    logic [15:0] model;   // stored word as the bench believes it
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    swf_unit i_swf_unit (
        .clk(clk), .rst_n(rst_n), .res_i(res_i), .wide_i(wide_i), .cb_i(cb_i),
        .op_i(op_i), .upd_i(upd_i), .ext_mode_i(ext_mode_i), .wr_i(wr_i),
        .wr_data_i(wr_data_i), .sw_o(sw_o)
    );

    function automatic logic [3:0] ref_flags(logic [31:0] r, bit w, bit cb, logic [1:0] op);
        longint v;
        logic   c;
        if (w) v = longint'($signed(r));
        else   v = longint'($signed(r[15:0]));
        if (op == 2'd0)      c = cb;
        else if (op == 2'd1) c = !cb;
        else                 c = 1'b0;
        return {c, v > 0, v == 0, v < 0};
    endfunction

    task automatic compare(string tag);
        logic [15:0] exp;
        exp = model;
        if (!ext_mode_i) exp[11:8] = 4'h0;
        n_vec++;
        if (sw_o !== exp) begin
            n_bad++;
            $display("FAIL %s: sw_o=%h expected %h", tag, sw_o, exp);
        end
    endtask

    task automatic step(string tag, logic [31:0] r, bit w, bit cb, logic [1:0] op,
                        bit upd, bit mode, bit wr, logic [15:0] wd);
        res_i = r; wide_i = w; cb_i = cb; op_i = op;
        upd_i = upd; ext_mode_i = mode; wr_i = wr; wr_data_i = wd;
        @(posedge clk);
        if (wr) model = wd;
        else if (upd) model[15:12] = ref_flags(r, w, cb, op);
        if (!mode) model[11:8] = 4'h0;
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        rst_n = 1'b0; res_i = '0; wide_i = 0; cb_i = 0; op_i = 0;
        upd_i = 0; ext_mode_i = 1; wr_i = 0; wr_data_i = 16'hFFFF;
        model = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare("R1 in reset");
        rst_n = 1'b1;
        step("R1 first cycle after reset", 32'h0, 0, 0, 2'd0, 0, 1, 0, 16'h0);

        // R9 and R2: full write, then priority over update
        step("R9 write word", 32'h0, 0, 0, 2'd0, 0, 1, 1, 16'h5A3C);
        step("R9 write beats update", 32'h1, 0, 1, 2'd0, 1, 1, 1, 16'h2C71);
        // R8: update touches only the flag nibble
        step("R8 R2 add positive carry", 32'h0000_0005, 0, 1, 2'd0, 1, 1, 0, 16'h0);
        step("R8 hold", 32'hFFFF_FFFF, 1, 0, 2'd1, 0, 1, 0, 16'hFFFF);
        // R3 carry semantics
        step("R3 add no carry", 32'h0000_0000, 0, 0, 2'd0, 1, 1, 0, 16'h0);
        step("R3 sub no borrow", 32'h0000_8000, 0, 0, 2'd1, 1, 1, 0, 16'h0);
        step("R3 sub borrow", 32'h0000_0001, 0, 1, 2'd1, 1, 1, 0, 16'h0);
        step("R3 logic 10 clears carry", 32'h0000_0000, 0, 1, 2'd2, 1, 1, 0, 16'h0);
        step("R3 logic 11 clears carry", 32'h0000_7FFF, 0, 1, 2'd3, 1, 1, 0, 16'h0);
        // R4 sign classes
        step("R4 narrow negative", 32'h0000_FFFF, 0, 0, 2'd0, 1, 1, 0, 16'h0);
        step("R4 narrow max positive", 32'h0000_7FFF, 0, 0, 2'd0, 1, 1, 0, 16'h0);
        // R5 width selection
        step("R5 narrow ignores upper zero", 32'hABCD_0000, 0, 0, 2'd0, 1, 1, 0, 16'h0);
        step("R5 narrow ignores upper sign", 32'h8000_0001, 0, 0, 2'd0, 1, 1, 0, 16'h0);
        step("R5 wide upper nonzero", 32'h0001_0000, 1, 0, 2'd0, 1, 1, 0, 16'h0);
        step("R5 wide low half looks negative", 32'h0000_8000, 1, 0, 2'd0, 1, 1, 0, 16'h0);
        step("R5 wide negative", 32'h8000_0000, 1, 1, 2'd0, 1, 1, 0, 16'h0);
        step("R5 wide zero", 32'h0000_0000, 1, 1, 2'd1, 1, 1, 0, 16'h0);
        // R7 bank retained in extended mode
        step("R7 write bank", 32'h0, 0, 0, 2'd0, 0, 1, 1, 16'h0A96);
        step("R7 bank through update", 32'hFFFF_FFF0, 1, 1, 2'd1, 1, 1, 0, 16'h0);
        step("R7 bank idle", 32'h0, 0, 0, 2'd0, 0, 1, 0, 16'h0);
        // R6 reduced mode
        step("R6 reads zero", 32'h0, 0, 0, 2'd0, 0, 0, 0, 16'h0);
        step("R6 write discards bank", 32'h0, 0, 0, 2'd0, 0, 0, 1, 16'hBFED);
        step("R6 update reduced", 32'h0000_0003, 0, 1, 2'd0, 1, 0, 0, 16'h0);
        step("R6 cleared after mode switch", 32'h0, 0, 0, 2'd0, 0, 1, 0, 16'h0);
        step("R7 reload bank", 32'h0, 0, 0, 2'd0, 0, 1, 1, 16'h1E42);
        // mixed sweep
        for (int k = 0; k < 40; k++) begin
            logic [31:0] r;
            r = 32'h9E37_79B9 * (k + 1);
            if (k % 7 == 0) r = 32'h0;
            step("R4 R5 R3 sweep", r, k[0], k[1], k[3:2], (k % 5) != 4,
                 (k % 9) != 8, (k % 11) == 3, r[31:16] ^ r[15:0]);
        end
        // R1 reset again after activity
        rst_n = 1'b0; model = '0;
        @(posedge clk); @(negedge clk);
        compare("R1 reset after activity");
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule